// File: doc/BRIEF.md
# MAC Domain Reset Sequencer

This block turns four write-one control bits into timed reset pulses for the separate domains of an Ethernet MAC: the statistics counters, the receive port, the transmit port and the MII management logic. Software writes a 1 to a bit to start the matching reset. The bit reads back as 1 for as long as that reset is being driven and returns to 0 by itself when the pulse ends, so a poll shows when the reset has completed.

The counter reset is stretched to a minimum hold of 40 clocks. The port resets are short fixed pulses. The software-reset bit fires all four domain resets together. It is honoured only while the MII management engine reports idle. A request made while that engine is busy is dropped and latches a sticky error flag. Only power-on reset clears that flag, and a software reset never disturbs it.

Top module: `mac_reset_sequencer`

## Requirements
- R1: After power-on reset (rstN low), all four reset outputs, all four readback bits and swErr are 0.
- R2: A write (wrEn high) with wrData[3] set drives cntRst high from the cycle after the write for exactly CNT_HOLD cycles (default 40). ctlRead[3] reads 1 for exactly those cycles.
- R3: A write with wrData[2] set drives only rxRst high for PORT_HOLD cycles (default 4). A write with wrData[1] set drives only txRst high for PORT_HOLD cycles. ctlRead[2] and ctlRead[1] follow the matching pulse.
- R4: A write with wrData[0] set while miiBusy is 0 raises cntRst, rxRst, txRst and miiRst in the next cycle. cntRst lasts CNT_HOLD cycles and the other three last PORT_HOLD cycles. ctlRead[0] reads 1 until cntRst ends.
- R5: A write with wrData[0] set while miiBusy is 1 starts no reset through that bit and sets swErr. swErr stays 1 until power-on reset.
- R6: An accepted software reset leaves swErr unchanged.
- R7: A cycle with wrEn low, and any zero bit of a write, starts nothing. miiRst rises only from an accepted software reset.
- R8: Writing 1 to wrData[3], wrData[2] or wrData[1] while that domain's reset is already active neither restarts nor extends the pulse.
- R9: The bits of one write act independently. A rejected software reset does not block the counter, receive or transmit bits written alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low power-on reset |
| wrEn | input | 1 | Control-register write strobe |
| wrData | input | 4 | Write data: [3] counter, [2] receive, [1] transmit, [0] software reset |
| miiBusy | input | 1 | MII management engine busy flag |
| ctlRead | output | 4 | Self-clearing readback of the four control bits |
| cntRst | output | 1 | Counter-domain reset, active high |
| rxRst | output | 1 | Receive-port reset, active high |
| txRst | output | 1 | Transmit-port reset, active high |
| miiRst | output | 1 | MII management reset, active high |
| swErr | output | 1 | Sticky flag: software reset requested while busy |

## Verification
The bench sweeps all sixteen write values under both states of the busy flag. For each case it counts how many cycles every reset output stays high and compares the count against lengths it works out from the bits written. An off-by-one hold counter, a software reset that leaks through while busy, or a rejected software reset that swallows its sibling bits all show up as a wrong pulse length. A second write of the counter bit in the middle of its pulse catches a design that reloads its timer, because the pulse then grows past 40. The error flag is followed across later accepted software resets to catch a design that clears it as part of the datapath reset.

// File: rtl/mac_reset_pkg.sv
package mac_reset_pkg;
  // write-data bit positions (software-visible layout)
  localparam int BIT_SW  = 0;
  localparam int BIT_TX  = 1;
  localparam int BIT_RX  = 2;
  localparam int BIT_CNT = 3;
  localparam int NUM_BITS = 4;

  // reset domain indices
  localparam int DOM_CNT = 0;
  localparam int DOM_RX  = 1;
  localparam int DOM_TX  = 2;
  localparam int DOM_MII = 3;
  localparam int NUM_DOM = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_DOM-1:0] load;     // start the hold timer of a domain
    logic               swAccept; // software reset taken
    logic               swReject; // software reset refused (MII busy)
  } rst_strobe_t;
endpackage

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              remain <= '0;
    else if (load)          remain <= HOLD_V;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/mac_reset_ctrl.sv
module mac_reset_ctrl
  import mac_reset_pkg::*;
(
  input  logic                wrEn,
  input  logic [NUM_BITS-1:0] wrData,
  input  logic                miiBusy,
  input  logic [NUM_DOM-1:0]  domActive,
  input  logic                swActive,
  output rst_strobe_t         strobe
);
  logic swReq, cntReq, rxReq, txReq;

  always_comb begin
    swReq  = wrEn & wrData[BIT_SW];
    cntReq = wrEn & wrData[BIT_CNT] & ~domActive[DOM_CNT];
    rxReq  = wrEn & wrData[BIT_RX]  & ~domActive[DOM_RX];
    txReq  = wrEn & wrData[BIT_TX]  & ~domActive[DOM_TX];

    strobe.swReject = swReq & miiBusy;
    strobe.swAccept = swReq & ~miiBusy & ~swActive;

    strobe.load          = '0;
    strobe.load[DOM_CNT] = cntReq | strobe.swAccept;
    strobe.load[DOM_RX]  = rxReq  | strobe.swAccept;
    strobe.load[DOM_TX]  = txReq  | strobe.swAccept;
    strobe.load[DOM_MII] = strobe.swAccept;
  end
endmodule

// File: rtl/mac_reset_datapath.sv
module mac_reset_datapath
  import mac_reset_pkg::*;
#(
  parameter int CNT_HOLD  = 40,
  parameter int PORT_HOLD = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  rst_strobe_t         strobe,
  output logic [NUM_DOM-1:0]  domActive,
  output logic                swActive,
  output logic                errFlag
);
  logic swOwn;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    localparam int H = (g == DOM_CNT) ? CNT_HOLD : PORT_HOLD;
    rst_hold_timer #(.HOLD(H)) u_timer (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobe.load[g]),
      .active (domActive[g])
    );
  end

  // software reset in progress: held until the longest pulse (counters) ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    swOwn <= 1'b0;
    else if (strobe.swAccept)     swOwn <= 1'b1;
    else if (!domActive[DOM_CNT]) swOwn <= 1'b0;
  end

  // sticky refusal flag, untouched by the domain resets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                errFlag <= 1'b0;
    else if (strobe.swReject) errFlag <= 1'b1;
  end

  assign swActive = swOwn & domActive[DOM_CNT];
endmodule

// File: rtl/mac_reset_sequencer.sv
module mac_reset_sequencer
  import mac_reset_pkg::*;
#(
  parameter int CNT_HOLD  = 40,
  parameter int PORT_HOLD = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [3:0] wrData,
  input  logic       miiBusy,
  output logic [3:0] ctlRead,
  output logic       cntRst,
  output logic       rxRst,
  output logic       txRst,
  output logic       miiRst,
  output logic       swErr
);
  rst_strobe_t        strobe;
  logic [NUM_DOM-1:0] domActive;
  logic               swActive;

  mac_reset_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrData    (wrData),
    .miiBusy   (miiBusy),
    .domActive (domActive),
    .swActive  (swActive),
    .strobe    (strobe)
  );

  mac_reset_datapath #(.CNT_HOLD(CNT_HOLD), .PORT_HOLD(PORT_HOLD)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .domActive (domActive),
    .swActive  (swActive),
    .errFlag   (swErr)
  );

  assign cntRst = domActive[DOM_CNT];
  assign rxRst  = domActive[DOM_RX];
  assign txRst  = domActive[DOM_TX];
  assign miiRst = domActive[DOM_MII];

  always_comb begin
    ctlRead          = '0;
    ctlRead[BIT_CNT] = domActive[DOM_CNT];
    ctlRead[BIT_RX]  = domActive[DOM_RX];
    ctlRead[BIT_TX]  = domActive[DOM_TX];
    ctlRead[BIT_SW]  = swActive;
  end
endmodule

// File: rtl/mac_reset_sequencer_chk.sv
module mac_reset_sequencer_chk #(
  parameter int CNT_HOLD  = 40,
  parameter int PORT_HOLD = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [3:0] wrData,
  input logic       miiBusy,
  input logic [3:0] ctlRead,
  input logic       cntRst,
  input logic       rxRst,
  input logic       txRst,
  input logic       miiRst,
  input logic       swErr
);
  logic [7:0] cntLen, rxLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLen <= '0;
      rxLen  <= '0;
    end else begin
      cntLen <= cntRst ? cntLen + 8'd1 : 8'd0;
      rxLen  <= rxRst  ? rxLen  + 8'd1 : 8'd0;
    end
  end

  assert_cnt_min_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cntRst) |-> (cntLen >= 8'(CNT_HOLD)));

  assert_rx_min_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxRst) |-> (rxLen >= 8'(PORT_HOLD)));

  assert_sw_fires_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0] && !miiBusy && !ctlRead[0]) |=> (cntRst && rxRst && txRst && miiRst));

  assert_busy_sets_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0] && miiBusy) |=> swErr);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    swErr |=> swErr);

  assert_busy_no_mii_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0] && miiBusy && !miiRst) |=> !miiRst);

  assert_mii_only_sw_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(miiRst) |-> $past(wrEn && wrData[0] && !miiBusy));

  assert_rx_needs_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxRst) |-> $past(wrEn));
endmodule

bind mac_reset_sequencer mac_reset_sequencer_chk #(
  .CNT_HOLD(CNT_HOLD), .PORT_HOLD(PORT_HOLD)
) u_chk (.*);

// File: tb/mac_reset_sequencer_tb.sv
module mac_reset_sequencer_tb;
  localparam int CNT_HOLD  = 40;
  localparam int PORT_HOLD = 4;
  localparam int WINDOW    = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrData = '0;
  logic miiBusy = 1'b0;
  logic [3:0] ctlRead;
  logic cntRst, rxRst, txRst, miiRst, swErr;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_reset_sequencer #(.CNT_HOLD(CNT_HOLD), .PORT_HOLD(PORT_HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .miiBusy(miiBusy),
    .ctlRead(ctlRead), .cntRst(cntRst), .rxRst(rxRst), .txRst(txRst),
    .miiRst(miiRst), .swErr(swErr)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // write v at the next edge, then count high cycles of every output
  task automatic writeAndMeasure(input logic [3:0] v, input logic busy,
                                 input int rewriteAt,
                                 output int lc, output int lr, output int lt,
                                 output int lm, output logic [3:0] firstRead);
    lc = 0; lr = 0; lt = 0; lm = 0;
    miiBusy = busy;
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    firstRead = ctlRead;
    for (int i = 0; i < WINDOW; i++) begin
      lc += int'(cntRst);
      lr += int'(rxRst);
      lt += int'(txRst);
      lm += int'(miiRst);
      if (ctlRead[3] != cntRst || ctlRead[2] != rxRst || ctlRead[1] != txRst) begin
        nChecks++; nFail++;
        $display("FAIL R2/R3 readback: got %b outputs c%0b r%0b t%0b", ctlRead, cntRst, rxRst, txRst);
      end
      if (i == rewriteAt) begin wrEn = 1'b1; wrData = 4'b1000; end
      else begin wrEn = 1'b0; wrData = '0; end
      @(negedge clk);
    end
    miiBusy = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int lc, lr, lt, lm;
    logic [3:0] fr;
    logic expErr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outputs", int'({cntRst, rxRst, txRst, miiRst, swErr}), 0);
    check("R1 readback", int'(ctlRead), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({cntRst, rxRst, txRst, miiRst, swErr, ctlRead}), 0);

    // R7: idle cycles and zero writes do nothing
    writeAndMeasure(4'b0000, 1'b0, -1, lc, lr, lt, lm, fr);
    check("R7 zero write", lc + lr + lt + lm, 0);

    // R8: rewrite of counter bit mid-pulse does not extend it
    writeAndMeasure(4'b1000, 1'b0, 10, lc, lr, lt, lm, fr);
    check("R8 no restart", lc, CNT_HOLD);

    // exhaustive sweep over write values and busy state
    expErr = 1'b0;
    for (int b = 0; b < 2; b++) begin
      for (int v = 0; v < 16; v++) begin
        logic acc;
        int ec, er, et, em;
        acc = v[0] && (b == 0);
        ec = (acc || v[3]) ? CNT_HOLD : 0;
        er = (acc || v[2]) ? PORT_HOLD : 0;
        et = (acc || v[1]) ? PORT_HOLD : 0;
        em = acc ? PORT_HOLD : 0;
        writeAndMeasure(4'(v), 1'(b), -1, lc, lr, lt, lm, fr);
        if (v[0] && b == 1) expErr = 1'b1;
        check($sformatf("R2/R4/R9 cnt len v=%0d busy=%0d", v, b), lc, ec);
        check($sformatf("R3/R4/R9 rx len v=%0d busy=%0d", v, b), lr, er);
        check($sformatf("R3/R4/R9 tx len v=%0d busy=%0d", v, b), lt, et);
        check($sformatf("R4/R5/R7 mii len v=%0d busy=%0d", v, b), lm, em);
        check($sformatf("R4 sw readback v=%0d busy=%0d", v, b), int'(fr[0]), int'(acc));
        check($sformatf("R5/R6 err v=%0d busy=%0d", v, b), int'(swErr), int'(expErr));
      end
    end

    // R6: an accepted software reset after the error leaves it set
    writeAndMeasure(4'b0001, 1'b0, -1, lc, lr, lt, lm, fr);
    check("R6 err kept", int'(swErr), 1);
    check("R4 sw count len", lc, CNT_HOLD);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule